// File: doc/BRIEF.md
# Cascadable Event Counter Pair with Event-Driven PWM

The block counts rising edges on two external event inputs that run with no fixed relation to the system clock. Each input feeds its own 8-bit half, low and high. The halves either count separately or are joined into one 16-bit counter, with the carry out of the low half advancing the high half. Each input is brought into the system clock domain by a two-flop synchronizer and a rising-edge detector. Every detected edge adds one to its half while that half is enabled and released from clear.

Software drives the block through a small register bus with a write strobe, an address and combinational read data. An overflow sets a sticky flag that drives the interrupt output until software clears it. The low half can also act as the timebase of a pulse-width stage. Its output is high while the low count is below a data value. The count restarts at zero after it reaches a compare value. The data and compare registers are locked while the stage runs, and the stage may only be started when data is below compare.

A three-state machine (PWM_OFF, PWM_HIGH, PWM_LOW) forms the output. From every state it goes to PWM_OFF when the stage is disabled. Otherwise it goes to PWM_HIGH when the low count is below data and to PWM_LOW when it is not.

Top module: `evt_cnt_pair`

## Requirements
- R1: After reset, both counts, every control bit, the flag, the PWM enable, the data and compare registers, `irq_o` and `pwm_o` are 0.
- R2: An event input that rises between two clock edges makes its half one higher after the third rising clock edge that follows. A half whose enable bit is 0 holds its value.
- R3: While a half's release bit is 0, that half is held at zero and ignores events.
- R4: With the cascade bit set, the high half advances by one each time the low half wraps from 255 to 0, and it ignores its own event input.
- R5: With cascade clear, a wrap of either half sets the flag. With cascade set, only a wrap of the high half sets it.
- R6: The flag stays set until a control write with bit 5 set, and `irq_o` equals the flag.
- R7: While the PWM enable is 1, writes to the data (address 4) and compare (address 5) registers are ignored. After the enable is cleared they take effect.
- R8: A write of bit 0 = 1 to address 3 sets the PWM enable only when data < compare, and otherwise leaves it at 0. A write of bit 0 = 0 always clears it.
- R9: While the PWM enable is 1, an event at a low count equal to compare returns the low half to 0 and sets no flag.
- R10: `pwm_o` is 1 one clock after a cycle in which the PWM is enabled and the low count is below data. It is 0 after any other cycle.
- R11: Register map for 3-bit addresses: 0 control (bit0 low enable, bit1 high enable, bit2 low release, bit3 high release, bit4 cascade, bit5 flag on read and clear on write), 1 low count, 2 high count, 3 PWM enable in bit 0, 4 data, 5 compare. Other addresses read 0.
- R12: While cascade and the low enable are both 1, a control write leaves the high enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_lo_i | input | 1 | Asynchronous event input of the low half |
| evt_hi_i | input | 1 | Asynchronous event input of the high half |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Overflow interrupt (sticky flag) |
| pwm_o | output | 1 | Event-driven PWM output |

## Verification
A count is due after the third clock edge that follows an event input rise. A register write is visible at the first edge after its strobe. The flag and `irq_o` change at the same edge as the wrapping count, and `pwm_o` trails the count by one edge. The bench drives every input at the falling edge. Its reference model advances at each rising edge using only the values from before that edge. The model is compared with `irq_o` and `pwm_o` at every falling edge, and read data is sampled just after the address settles. One directed check confirms that the count has not moved after two rising edges and has moved after the third.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        PWM_OFF  = 2'd0,
        PWM_HIGH = 2'd1,
        PWM_LOW  = 2'd2
    } pwm_state_e;

    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT_LO   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT_HI   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_PWM_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_PWM_DATA = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_PWM_CMP  = 3'd5;

    localparam int BIT_EN_LO  = 0;
    localparam int BIT_EN_HI  = 1;
    localparam int BIT_RUN_LO = 2;
    localparam int BIT_RUN_HI = 3;
    localparam int BIT_CASC   = 4;
    localparam int BIT_FLAG   = 5;

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[LAST-1:0], pin_i};
        end
    end

    // a rise is seen once the synchronized level is 1 and the delayed copy is 0
    assign rise_o = shift_q[LAST-1] & ~shift_q[LAST];
endmodule

// File: rtl/evt_half_cnt.sv
module evt_half_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic         wrap_en_i,
    input  logic [W-1:0] wrap_at_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] MAX_VAL = '1;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            if (wrap_en_i && (cnt_q == wrap_at_i)) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ovf_o = inc_i & ~clr_i & ~wrap_en_i & (cnt_q == MAX_VAL);
    assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_pwm_fsm.sv
module evt_pwm_fsm
    import evt_cnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] data_i,
    output logic         pwm_o
);
    pwm_state_e state_q;
    pwm_state_e state_d;
    logic       below;

    assign below = (cnt_i < data_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWM_OFF: begin
                if (en_i) state_d = below ? PWM_HIGH : PWM_LOW;
            end
            PWM_HIGH: begin
                if (!en_i)      state_d = PWM_OFF;
                else if (!below) state_d = PWM_LOW;
            end
            PWM_LOW: begin
                if (!en_i)      state_d = PWM_OFF;
                else if (below) state_d = PWM_HIGH;
            end
            default: state_d = PWM_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWM_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pwm_o = (state_q == PWM_HIGH);
    end
endmodule

// File: rtl/evt_cnt_pair.sv
module evt_cnt_pair
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_lo_i,
    input  logic              evt_hi_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic              irq_o,
    output logic              pwm_o
);
    localparam int NUM_HALVES = 2;
    localparam int IDX_LO     = 0;
    localparam int IDX_HI     = 1;

    logic [NUM_HALVES-1:0] pins;
    logic [NUM_HALVES-1:0] rise;

    logic en_lo_q, en_hi_q, run_lo_q, run_hi_q, casc_q, flag_q, pwm_en_q;
    logic [CNT_W-1:0] pwm_data_q, pwm_cmp_q;
    logic [CNT_W-1:0] cnt_lo, cnt_hi;
    logic ovf_lo, ovf_hi;
    logic inc_lo, inc_hi;
    logic flag_set;
    logic wr_ctrl, wr_pwm_ctrl, wr_data, wr_cmp;
    logic hi_en_locked;

    assign pins = {evt_hi_i, evt_lo_i};

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_sync
        evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[g]),
            .rise_o (rise[g])
        );
    end

    assign inc_lo = en_lo_q & rise[IDX_LO];
    assign inc_hi = en_hi_q & (casc_q ? ovf_lo : rise[IDX_HI]);

    evt_half_cnt #(.W(CNT_W)) u_lo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (~run_lo_q),
        .inc_i     (inc_lo),
        .wrap_en_i (pwm_en_q),
        .wrap_at_i (pwm_cmp_q),
        .cnt_o     (cnt_lo),
        .ovf_o     (ovf_lo)
    );

    evt_half_cnt #(.W(CNT_W)) u_hi (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (~run_hi_q),
        .inc_i     (inc_hi),
        .wrap_en_i (1'b0),
        .wrap_at_i ('0),
        .cnt_o     (cnt_hi),
        .ovf_o     (ovf_hi)
    );

    assign flag_set     = casc_q ? ovf_hi : (ovf_hi | ovf_lo);
    assign wr_ctrl      = bus_wr_i && (bus_addr_i == ADDR_CTRL);
    assign wr_pwm_ctrl  = bus_wr_i && (bus_addr_i == ADDR_PWM_CTRL);
    assign wr_data      = bus_wr_i && (bus_addr_i == ADDR_PWM_DATA);
    assign wr_cmp       = bus_wr_i && (bus_addr_i == ADDR_PWM_CMP);
    assign hi_en_locked = casc_q & en_lo_q;

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_lo_q  <= 1'b0;
            en_hi_q  <= 1'b0;
            run_lo_q <= 1'b0;
            run_hi_q <= 1'b0;
            casc_q   <= 1'b0;
        end else if (wr_ctrl) begin
            en_lo_q  <= bus_wdata_i[BIT_EN_LO];
            run_lo_q <= bus_wdata_i[BIT_RUN_LO];
            run_hi_q <= bus_wdata_i[BIT_RUN_HI];
            casc_q   <= bus_wdata_i[BIT_CASC];
            if (!hi_en_locked) begin
                en_hi_q <= bus_wdata_i[BIT_EN_HI];
            end
        end
    end

    // sticky overflow flag, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (flag_set) begin
            flag_q <= 1'b1;
        end else if (wr_ctrl && bus_wdata_i[BIT_FLAG]) begin
            flag_q <= 1'b0;
        end
    end

    // PWM enable with order check, data and compare locked while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_en_q   <= 1'b0;
            pwm_data_q <= '0;
            pwm_cmp_q  <= '0;
        end else begin
            if (wr_pwm_ctrl) begin
                if (!bus_wdata_i[0]) begin
                    pwm_en_q <= 1'b0;
                end else if (pwm_data_q < pwm_cmp_q) begin
                    pwm_en_q <= 1'b1;
                end
            end
            if (wr_data && !pwm_en_q) pwm_data_q <= bus_wdata_i;
            if (wr_cmp  && !pwm_en_q) pwm_cmp_q  <= bus_wdata_i;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            ADDR_CTRL: begin
                bus_rdata_o[BIT_EN_LO]  = en_lo_q;
                bus_rdata_o[BIT_EN_HI]  = en_hi_q;
                bus_rdata_o[BIT_RUN_LO] = run_lo_q;
                bus_rdata_o[BIT_RUN_HI] = run_hi_q;
                bus_rdata_o[BIT_CASC]   = casc_q;
                bus_rdata_o[BIT_FLAG]   = flag_q;
            end
            ADDR_CNT_LO:   bus_rdata_o = cnt_lo;
            ADDR_CNT_HI:   bus_rdata_o = cnt_hi;
            ADDR_PWM_CTRL: bus_rdata_o[0] = pwm_en_q;
            ADDR_PWM_DATA: bus_rdata_o = pwm_data_q;
            ADDR_PWM_CMP:  bus_rdata_o = pwm_cmp_q;
            default:       bus_rdata_o = '0;
        endcase
    end

    evt_pwm_fsm #(.W(CNT_W)) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (pwm_en_q),
        .cnt_i  (cnt_lo),
        .data_i (pwm_data_q),
        .pwm_o  (pwm_o)
    );

    assign irq_o = flag_q;
endmodule

// File: rtl/evt_cnt_pair_chk.sv
module evt_cnt_pair_chk
    import evt_cnt_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic              en_lo,
    input logic              en_hi,
    input logic              run_lo,
    input logic              casc,
    input logic              flag,
    input logic              pwm_en,
    input logic              pwm_o,
    input logic [W-1:0]      cnt_lo,
    input logic [W-1:0]      pwm_data,
    input logic [W-1:0]      pwm_cmp
);
    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_lo |=> (cnt_lo == '0)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(bus_wr && bus_addr == ADDR_CTRL && bus_wdata[BIT_FLAG]) |=> flag); // R6

    AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |=> ($stable(pwm_data) && $stable(pwm_cmp))); // R7

    AST_PWM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |-> (pwm_data < pwm_cmp)); // R8

    AST_PWM_WRAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en && (cnt_lo <= pwm_cmp) |=> (cnt_lo <= pwm_cmp)); // R9

    AST_PWM_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |=> !pwm_o); // R10

    AST_HI_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        casc && en_lo |=> $stable(en_hi)); // R12
endmodule

bind evt_cnt_pair evt_cnt_pair_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .en_lo     (en_lo_q),
    .en_hi     (en_hi_q),
    .run_lo    (run_lo_q),
    .casc      (casc_q),
    .flag      (flag_q),
    .pwm_en    (pwm_en_q),
    .pwm_o     (pwm_o),
    .cnt_lo    (cnt_lo),
    .pwm_data  (pwm_data_q),
    .pwm_cmp   (pwm_cmp_q)
);

// File: tb/evt_cnt_pair_bench.sv
module evt_cnt_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_lo = 1'b0;
    logic       evt_hi = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       pwm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evt_cnt_pair u_evt_cnt_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_lo_i    (evt_lo),
        .evt_hi_i    (evt_hi),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq),
        .pwm_o       (pwm)
    );

    // behavioural reference model, advanced at each rising edge from old values
    int m_p1[2], m_p2[2], m_p3[2];
    int m_lo, m_hi, m_data, m_cmp;
    bit m_en_lo, m_en_hi, m_run_lo, m_run_hi, m_casc, m_flag, m_pwm_en, m_pwm;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin m_p1[i] = 0; m_p2[i] = 0; m_p3[i] = 0; end
            m_lo = 0; m_hi = 0; m_data = 0; m_cmp = 0;
            m_en_lo = 0; m_en_hi = 0; m_run_lo = 0; m_run_hi = 0;
            m_casc = 0; m_flag = 0; m_pwm_en = 0; m_pwm = 0;
        end else begin
            bit e_lo, e_hi, w_lo, w_hi, step_hi, setf;
            int n_lo, n_hi;
            e_lo = (m_p2[0] == 1) && (m_p3[0] == 0);
            e_hi = (m_p2[1] == 1) && (m_p3[1] == 0);
            for (int i = 0; i < 2; i++) begin m_p3[i] = m_p2[i]; m_p2[i] = m_p1[i]; end
            m_p1[0] = evt_lo; m_p1[1] = evt_hi;
            w_lo = 0; w_hi = 0;
            n_lo = m_lo;
            if (!m_run_lo) n_lo = 0;
            else if (m_en_lo && e_lo) begin
                if (m_pwm_en && m_lo == m_cmp) n_lo = 0;
                else begin
                    n_lo = (m_lo + 1) % 256;
                    if (m_lo == 255 && !m_pwm_en) w_lo = 1;
                end
            end
            step_hi = m_en_hi && (m_casc ? w_lo : e_hi);
            n_hi = m_hi;
            if (!m_run_hi) n_hi = 0;
            else if (step_hi) begin
                n_hi = (m_hi + 1) % 256;
                if (m_hi == 255) w_hi = 1;
            end
            setf = m_casc ? w_hi : (w_hi || w_lo);
            m_pwm = m_pwm_en && (m_lo < m_data);
            if (setf) m_flag = 1;
            else if (bus_wr && bus_addr == 0 && bus_wdata[5]) m_flag = 0;
            if (bus_wr && bus_addr == 0) begin
                if (!(m_casc && m_en_lo)) m_en_hi = bus_wdata[1];
                m_en_lo = bus_wdata[0]; m_run_lo = bus_wdata[2];
                m_run_hi = bus_wdata[3]; m_casc = bus_wdata[4];
            end
            if (bus_wr && bus_addr == 4 && !m_pwm_en) m_data = bus_wdata;
            if (bus_wr && bus_addr == 5 && !m_pwm_en) m_cmp = bus_wdata;
            if (bus_wr && bus_addr == 3) begin
                if (!bus_wdata[0]) m_pwm_en = 0;
                else if (m_data < m_cmp) m_pwm_en = 1;
            end
            m_lo = n_lo; m_hi = n_hi;
        end
    end

    // every-clock comparison of the outputs against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_flag) begin
                errors++;
                $display("FAIL R6 irq_o actual=%0b expected=%0b", irq, m_flag);
            end
            checks++;
            if (pwm !== m_pwm) begin
                errors++;
                $display("FAIL R10 pwm_o actual=%0b expected=%0b", pwm, m_pwm);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd_now(input logic [2:0] a, input int exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic rd(input logic [2:0] a, input int exp, input string tag);
        @(negedge clk);
        rd_now(a, exp, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input bit hi, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (hi) evt_hi = 1'b1; else evt_lo = 1'b1;
            @(negedge clk);
            @(negedge clk);
            if (hi) evt_hi = 1'b0; else evt_lo = 1'b0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) rd(3'(a), 0, "R1");
        check("R1 irq", int'(irq), 0);
        check("R1 pwm", int'(pwm), 0);

        // R2 latency and counting, 8-bit mode
        wr(3'd0, 8'h0F);
        rd(3'd0, 8'h0F, "R11 ctrl");
        @(negedge clk); evt_lo = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_now(3'd1, 0, "R2 before third edge");
        @(negedge clk);
        rd_now(3'd1, 1, "R2 after third edge");
        evt_lo = 1'b0;
        repeat (3) @(negedge clk);
        pulse(0, 4);
        pulse(1, 3);
        rd(3'd1, 5, "R2 low count");
        rd(3'd2, 3, "R2 high count");

        // R2 disabled half holds
        wr(3'd0, 8'h0E);
        pulse(0, 3);
        rd(3'd1, 5, "R2 disabled hold");

        // R3 release bit low holds zero
        wr(3'd0, 8'h0B);
        rd(3'd1, 0, "R3 cleared");
        pulse(0, 2);
        rd(3'd1, 0, "R3 held at zero");

        // R5 8-bit overflow of low half
        wr(3'd0, 8'h0F);
        pulse(0, 255);
        rd(3'd1, 255, "R5 low at max");
        check("R5 no flag yet", int'(irq), 0);
        pulse(0, 1);
        rd(3'd1, 0, "R5 low wrapped");
        check("R5 flag set", int'(irq), 1);
        wr(3'd0, 8'h0F);
        @(negedge clk);
        check("R6 flag sticky", int'(irq), 1);
        rd(3'd0, 8'h2F, "R11 ctrl flag bit");
        wr(3'd0, 8'h20);
        @(negedge clk);
        check("R6 flag cleared", int'(irq), 0);

        // R4 / R12 cascade
        wr(3'd0, 8'h1F);
        wr(3'd0, 8'h1D);
        rd(3'd0, 8'h1F, "R12 high enable locked");
        pulse(1, 2);
        rd(3'd2, 0, "R4 own pin ignored");
        pulse(0, 256);
        rd(3'd1, 0, "R4 low wrapped");
        rd(3'd2, 1, "R4 carry into high");
        check("R5 no flag on low wrap in cascade", int'(irq), 0);

        // PWM
        wr(3'd0, 8'h20);
        wr(3'd0, 8'h05);
        wr(3'd4, 8'd5);
        wr(3'd5, 8'd3);
        wr(3'd3, 8'd1);
        rd(3'd3, 0, "R8 refused data>cmp");
        wr(3'd4, 8'd3);
        wr(3'd3, 8'd1);
        rd(3'd3, 0, "R8 refused data==cmp");
        wr(3'd4, 8'd2);
        wr(3'd5, 8'd4);
        wr(3'd3, 8'd1);
        rd(3'd3, 1, "R8 accepted");
        wr(3'd4, 8'd7);
        rd(3'd4, 2, "R7 data locked");
        wr(3'd5, 8'd9);
        rd(3'd5, 4, "R7 compare locked");
        pulse(0, 12);
        rd(3'd1, 2, "R9 wrap at compare");
        check("R10 pwm low at data", int'(pwm), 0);
        pulse(0, 3);
        rd(3'd1, 0, "R9 restart at zero");
        check("R10 pwm high below data", int'(pwm), 1);
        check("R9 no flag", int'(irq), 0);
        wr(3'd3, 8'd0);
        wr(3'd4, 8'd7);
        rd(3'd4, 7, "R7 write after disable");
        @(negedge clk);
        check("R10 pwm off", int'(pwm), 0);
        rd(3'd6, 0, "R11 unused address");
        rd(3'd0, 8'h05, "R11 ctrl readback");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule